// File: doc/BRIEF.md
# Redundant-Radix Stage Code to Binary Converter

This block sits behind one slice of a pipelined analog-to-digital converter. Each sample carries two raw inputs. The first is a 15-line thermometer word from the first stage's flash comparators. The second is a word of single decision bits, one from each of the fifteen later stages. Each stage has a weight. Because the weights shrink by a ratio of about 1.7 rather than 2, the decisions carry redundancy, and the sample value is a weighted sum rather than a concatenation of bits. The block forms that sum. It rounds the sum to a 14-bit two's-complement code and clamps it to the 14-bit range.

Weights are unsigned 20-bit fixed-point numbers with 6 fractional bits. A calibration engine outside this block loads the first-stage weight and the weights of stages 2 to 11 through a simple write port. Stages 12 to 16 keep fixed nominal weights. The block accepts one sample per clock, marked by `in_valid`, and returns each result exactly four clocks later, marked by `out_valid`. There is no back-pressure.

Inside the block, samples pass through four named pipeline steps. CAPTURE forms all sixteen signed terms from the weights in force at that moment. GROUP adds the terms in sets of four. TOTAL adds the group sums. ROUND rounds, saturates and registers the output. No step can stall or skip, so each sample moves from one step to the next on every clock.

Top module: `rpc_converter`

## Requirements
- R1: When `in_valid` is high in cycle n, `out_valid` is high in cycle n+4 and carries that sample's result. `out_valid` is never high without a matching input, and back-to-back samples are accepted on every clock.
- R2: Reset (`rst_n` low, asynchronous) clears `out_valid` and `out_code` to 0 and loads every weight with its nominal value.
- R3: The first-stage level L is the number of set bits in `in_therm` (0 to 15, bubbles allowed). The level adds (2L - 15) times the stage-1 weight.
- R4: `in_bits[j]` is the decision of stage j+2. A 1 adds that stage's weight and a 0 subtracts it.
- R5: Weights are unsigned, 20 bits wide, with 6 fractional bits. The nominal stage-1 weight is 32768 (512.0) and the nominal stage-2 weight is 19200 (300.0). Each later nominal weight is (previous*10 + 8)/17 in integer division.
- R6: A write with `wr_sel` = 0 loads the stage-1 weight. A write with `wr_sel` = k, for k from 1 to 10, loads the weight of stage k+1. The new value is taken at the clock edge where `wr_en` is high.
- R7: Writes with `wr_sel` from 11 to 15 are ignored. The weights of stages 12 to 16 never change.
- R8: A sample accepted in the same cycle as a weight write uses the old weight. Samples accepted in later cycles use the new weight. No sum ever mixes the two.
- R9: The raw sum S, in 1/64 units, becomes floor((S + 32) / 64), so halves round toward positive infinity.
- R10: A rounded value above 8191 gives 8191, and one below -8192 gives -8192, with no wrap-around.
- R11: `out_code` holds the last result for as long as `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample present on the inputs this cycle |
| in_therm | input | 15 | First-stage comparator outputs, thermometer style |
| in_bits | input | 15 | Stage 2..16 decisions, bit j belongs to stage j+2 |
| wr_en | input | 1 | Weight write strobe |
| wr_sel | input | 4 | Weight select: 0 is stage 1, k in 1..10 is stage k+1 |
| wr_weight | input | 20 | Weight value, unsigned with 6 fractional bits |
| out_valid | output | 1 | Result present on `out_code` |
| out_code | output | 14 | Two's-complement result |

## Verification
The bench drives samples that push the sum past both ends of the code range; a design that wrapped would return a code of the wrong sign. It sets the weights so that raw sums land on exact halves, both positive and negative; a design that truncated, or rounded halves away from zero, would be off by one there. It writes a weight in the same cycle as a sample is accepted, then sends the same sample again; a design that used the new weight too early would change the first result. It also writes to the fixed-stage selects and feeds bubbled thermometer words; a design that decoded the select too loosely, or treated the thermometer as binary, would change results it should leave alone.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    // Class of a weight slot as seen from the write port.
    typedef enum logic [1:0] {
        WK_COARSE = 2'd0,
        WK_CAL    = 2'd1,
        WK_FIXED  = 2'd2
    } weight_kind_e;

    function automatic weight_kind_e kind_of(input int unsigned sel, input int unsigned n_cal);
        if (sel == 0)
            return WK_COARSE;
        else if (sel <= n_cal)
            return WK_CAL;
        else
            return WK_FIXED;
    endfunction

    // Nominal weight of slot idx: slot 0 is the first stage, slot 1 the
    // second, each further slot shrinks by num/den with rounding.
    function automatic int unsigned nominal_weight(input int unsigned idx,
                                                   input int unsigned coarse_nom,
                                                   input int unsigned fine_nom,
                                                   input int unsigned num,
                                                   input int unsigned den);
        int unsigned w;
        if (idx == 0)
            return coarse_nom;
        w = fine_nom;
        for (int unsigned k = 1; k < idx; k++)
            w = (w * num + den / 2) / den;
        return w;
    endfunction

endpackage

// File: rtl/rpc_weight_bank.sv
module rpc_weight_bank #(
    parameter int WEIGHT_W   = 20,
    parameter int N_FINE     = 15,
    parameter int N_CAL      = 10,
    parameter int COARSE_NOM = 32768,
    parameter int FINE_NOM   = 19200,
    parameter int RADIX_NUM  = 10,
    parameter int RADIX_DEN  = 17,
    localparam int SEL_W     = $clog2(N_FINE + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [WEIGHT_W-1:0]            wr_weight,
    output logic [N_FINE:0][WEIGHT_W-1:0]  weights
);

    for (genvar g = 0; g <= N_FINE; g++) begin : g_slot
        localparam int unsigned NOM =
            rpc_pkg::nominal_weight(g, COARSE_NOM, FINE_NOM, RADIX_NUM, RADIX_DEN);

        if (g <= N_CAL) begin : g_prog
            logic [WEIGHT_W-1:0] w_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    w_q <= WEIGHT_W'(NOM);
                else if (wr_en && (wr_sel == SEL_W'(g)))
                    w_q <= wr_weight;
            end

            assign weights[g] = w_q;
        end else begin : g_fixed
            assign weights[g] = WEIGHT_W'(NOM);
        end
    end

endmodule

// File: rtl/rpc_term_gen.sv
module rpc_term_gen #(
    parameter int WEIGHT_W = 20,
    parameter int LVL_W    = 4,
    parameter int N_FINE   = 15,
    parameter int ACC_W    = 30,
    localparam int N_THR   = (2 ** LVL_W) - 1,
    localparam int FAC_W   = LVL_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [N_THR-1:0]               in_therm,
    input  logic [N_FINE-1:0]              in_bits,
    input  logic [N_FINE:0][WEIGHT_W-1:0]  weights,
    output logic                           t_valid,
    output logic [N_FINE:0][ACC_W-1:0]     terms
);

    logic [LVL_W:0]            level;
    logic signed [FAC_W-1:0]   factor;
    logic signed [ACC_W-1:0]   fac_x;
    logic signed [ACC_W-1:0]   wc_x;
    logic [N_FINE:0][ACC_W-1:0] terms_d;

    // CAPTURE step: first-stage term, odd factor in -N_THR..+N_THR.
    assign level   = (LVL_W + 1)'($countones(in_therm));
    assign factor  = $signed({level, 1'b0}) - $signed(FAC_W'(N_THR));
    assign fac_x   = {{(ACC_W - FAC_W){factor[FAC_W-1]}}, factor};
    assign wc_x    = {{(ACC_W - WEIGHT_W){1'b0}}, weights[0]};
    assign terms_d[0] = fac_x * wc_x;

    // One signed +/- term per later stage.
    for (genvar j = 0; j < N_FINE; j++) begin : g_fine
        logic [ACC_W-1:0] wx;
        assign wx = {{(ACC_W - WEIGHT_W){1'b0}}, weights[j+1]};
        assign terms_d[j+1] = in_bits[j] ? wx : (ACC_W'(0) - wx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_valid <= 1'b0;
            terms   <= '0;
        end else begin
            t_valid <= in_valid;
            if (in_valid)
                terms <= terms_d;
        end
    end

endmodule

// File: rtl/rpc_adder_tree.sv
module rpc_adder_tree #(
    parameter int ACC_W   = 30,
    parameter int N_TERMS = 16,
    parameter int GROUP   = 4,
    localparam int N_GRP  = (N_TERMS + GROUP - 1) / GROUP,
    localparam int N_PAD  = N_GRP * GROUP
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           t_valid,
    input  logic [N_TERMS-1:0][ACC_W-1:0]  terms,
    output logic                           s_valid,
    output logic signed [ACC_W-1:0]        total
);

    logic [N_PAD-1:0][ACC_W-1:0] padded;
    logic [N_GRP-1:0][ACC_W-1:0] part_d;
    logic [N_GRP-1:0][ACC_W-1:0] part_q;
    logic [ACC_W-1:0]            total_d;
    logic                        p_valid;

    for (genvar p = 0; p < N_PAD; p++) begin : g_pad
        if (p < N_TERMS) begin : g_term
            assign padded[p] = terms[p];
        end else begin : g_zero
            assign padded[p] = '0;
        end
    end

    // GROUP step: one adder per set of GROUP terms.
    for (genvar g = 0; g < N_GRP; g++) begin : g_group
        logic [ACC_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int k = 0; k < GROUP; k++)
                acc = acc + padded[g*GROUP + k];
        end
        assign part_d[g] = acc;
    end

    // TOTAL step: sum of the group results.
    always_comb begin
        total_d = '0;
        for (int g = 0; g < N_GRP; g++)
            total_d = total_d + part_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            part_q  <= '0;
            s_valid <= 1'b0;
            total   <= '0;
        end else begin
            p_valid <= t_valid;
            part_q  <= part_d;
            s_valid <= p_valid;
            total   <= $signed(total_d);
        end
    end

endmodule

// File: rtl/rpc_round_sat.sv
module rpc_round_sat #(
    parameter int ACC_W  = 30,
    parameter int FRAC_W = 6,
    parameter int OUT_W  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s_valid,
    input  logic signed [ACC_W-1:0]  total,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_code
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC_W - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -ACC_W'(1 << (OUT_W - 1));

    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;
    logic [OUT_W-1:0]        code_d;
    logic                    unused_frac;

    // ROUND step: bias by one half, arithmetic shift, clamp.
    assign biased      = total + HALF;
    assign scaled      = biased >>> FRAC_W;
    assign unused_frac = ^biased[FRAC_W-1:0];

    always_comb begin
        if (scaled > MAXV)
            code_d = MAXV[OUT_W-1:0];
        else if (scaled < MINV)
            code_d = MINV[OUT_W-1:0];
        else
            code_d = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= s_valid;
            if (s_valid)
                out_code <= $signed(code_d);
        end
    end

endmodule

// File: rtl/rpc_converter.sv
module rpc_converter #(
    parameter int WEIGHT_W   = 20,
    parameter int FRAC_W     = 6,
    parameter int OUT_W      = 14,
    parameter int LVL_W      = 4,
    parameter int N_FINE     = 15,
    parameter int N_CAL      = 10,
    parameter int COARSE_NOM = 32768,
    parameter int FINE_NOM   = 19200,
    parameter int RADIX_NUM  = 10,
    parameter int RADIX_DEN  = 17,
    parameter int GROUP      = 4,
    localparam int N_THR     = (2 ** LVL_W) - 1,
    localparam int SEL_W     = $clog2(N_FINE + 1),
    localparam int ACC_W     = WEIGHT_W + LVL_W + 2 + $clog2(N_FINE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [N_THR-1:0]         in_therm,
    input  logic [N_FINE-1:0]        in_bits,
    input  logic                     wr_en,
    input  logic [SEL_W-1:0]         wr_sel,
    input  logic [WEIGHT_W-1:0]      wr_weight,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_code
);

    logic [N_FINE:0][WEIGHT_W-1:0] weights;
    logic                          t_valid;
    logic [N_FINE:0][ACC_W-1:0]    terms;
    logic                          s_valid;
    logic signed [ACC_W-1:0]       total;

    rpc_weight_bank #(
        .WEIGHT_W   (WEIGHT_W),
        .N_FINE     (N_FINE),
        .N_CAL      (N_CAL),
        .COARSE_NOM (COARSE_NOM),
        .FINE_NOM   (FINE_NOM),
        .RADIX_NUM  (RADIX_NUM),
        .RADIX_DEN  (RADIX_DEN)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_weight (wr_weight),
        .weights   (weights)
    );

    rpc_term_gen #(
        .WEIGHT_W (WEIGHT_W),
        .LVL_W    (LVL_W),
        .N_FINE   (N_FINE),
        .ACC_W    (ACC_W)
    ) i_terms (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_therm (in_therm),
        .in_bits  (in_bits),
        .weights  (weights),
        .t_valid  (t_valid),
        .terms    (terms)
    );

    rpc_adder_tree #(
        .ACC_W   (ACC_W),
        .N_TERMS (N_FINE + 1),
        .GROUP   (GROUP)
    ) i_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .t_valid (t_valid),
        .terms   (terms),
        .s_valid (s_valid),
        .total   (total)
    );

    rpc_round_sat #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .OUT_W  (OUT_W)
    ) i_round (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .total     (total),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

endmodule

// File: rtl/rpc_converter_chk.sv
module rpc_converter_chk #(
    parameter int WEIGHT_W = 20,
    parameter int N_FINE   = 15,
    parameter int N_CAL    = 10,
    parameter int ACC_W    = 30,
    parameter int FRAC_W   = 6,
    parameter int OUT_W    = 14,
    parameter int SEL_W    = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_valid,
    input logic                           wr_en,
    input logic [SEL_W-1:0]               wr_sel,
    input logic [WEIGHT_W-1:0]            wr_weight,
    input logic [N_FINE:0][WEIGHT_W-1:0]  weights,
    input logic                           s_valid,
    input logic signed [ACC_W-1:0]        total,
    input logic                           out_valid,
    input logic signed [OUT_W-1:0]        out_code
);

    localparam longint MAXV   = (longint'(1) << (OUT_W - 1)) - 1;
    localparam longint MINV   = -(MAXV + 1);
    localparam longint HALF   = longint'(1) << (FRAC_W - 1);
    localparam longint HI_LIM = ((MAXV + 1) << FRAC_W) - HALF;
    localparam longint LO_LIM = (MINV * (longint'(1) << FRAC_W)) - HALF;

    logic [2:0]           since_rst;
    logic                 load_q;
    logic [SEL_W-1:0]     sel_q;
    logic [WEIGHT_W-1:0]  val_q;
    logic                 loads;

    assign loads = wr_en &&
        (rpc_pkg::kind_of(int'(wr_sel), N_CAL) != rpc_pkg::WK_FIXED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            load_q    <= 1'b0;
            sel_q     <= '0;
            val_q     <= '0;
        end else begin
            if (since_rst != 3'd4)
                since_rst <= since_rst + 3'd1;
            load_q <= loads;
            sel_q  <= wr_sel;
            val_q  <= wr_weight;
        end
    end

    // R1: valid reappears exactly four clocks after acceptance
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R6: a write to a programmable slot lands in that slot
    a_r6_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |-> (weights[sel_q] == val_q));

    // R7: without a write to a programmable slot, no weight moves
    a_r7_fixed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !loads |=> $stable(weights));

    // R10: sums past the top clamp to the largest code
    a_r10_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && (longint'(total) >= HI_LIM)) |=> (longint'(out_code) == MAXV));

    // R10: sums past the bottom clamp to the smallest code
    a_r10_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && (longint'(total) < LO_LIM)) |=> (longint'(out_code) == MINV));

    // R11: code holds while nothing completes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |=> $stable(out_code));

endmodule

bind rpc_converter rpc_converter_chk #(
    .WEIGHT_W (WEIGHT_W),
    .N_FINE   (N_FINE),
    .N_CAL    (N_CAL),
    .ACC_W    (ACC_W),
    .FRAC_W   (FRAC_W),
    .OUT_W    (OUT_W),
    .SEL_W    (SEL_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_weight (wr_weight),
    .weights   (weights),
    .s_valid   (s_valid),
    .total     (total),
    .out_valid (out_valid),
    .out_code  (out_code)
);

// File: tb/test_rpc_converter.sv
module test_rpc_converter;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] in_therm = '0;
    logic [14:0] in_bits = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [19:0] wr_weight = '0;
    logic        out_valid;
    logic signed [13:0] out_code;

    always #4 clk = ~clk;   // 125 MHz

    rpc_converter i_rpc_converter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_therm  (in_therm),
        .in_bits   (in_bits),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_weight (wr_weight),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    int     checks = 0;
    int     fails = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    longint wm [16];
    longint exp_q [$];
    int     cyc_q [$];
    string  tag_q [$];
    longint last_exp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // R5: nominal weights
    task automatic load_nominal();
        longint w;
        wm[0] = 32768;
        w = 19200;
        wm[1] = w;
        for (int k = 2; k < 16; k++) begin
            w = (w * 10 + 8) / 17;
            wm[k] = w;
        end
    endtask

    function automatic longint model(input logic [14:0] th, input logic [14:0] b);
        longint s;
        longint r;
        int     lvl;
        lvl = $countones(th);
        s = longint'(2 * lvl - 15) * wm[0];
        for (int j = 0; j < 15; j++)
            s = b[j] ? s + wm[j+1] : s - wm[j+1];
        r = (s + 32) >>> 6;
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    function automatic logic [14:0] therm(input int lvl);
        return 15'((32'd1 << lvl) - 1);
    endfunction

    task automatic push_exp(input longint e, input string tag);
        exp_q.push_back(e);
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            wr_en    = 1'b0;
        end
    endtask

    task automatic send(input logic [14:0] th, input logic [14:0] b, input string tag);
        @(negedge clk);
        wr_en    = 1'b0;
        in_valid = 1'b1;
        in_therm = th;
        in_bits  = b;
        push_exp(model(th, b), tag);
    endtask

    task automatic write_w(input int sel, input longint val);
        @(negedge clk);
        in_valid  = 1'b0;
        wr_en     = 1'b1;
        wr_sel    = 4'(sel);
        wr_weight = 20'(val);
        if (sel <= 10) wm[sel] = val;
    endtask

    // Sample and write in the same cycle: expectation uses old weights (R8)
    task automatic send_write(input logic [14:0] th, input logic [14:0] b,
                              input int sel, input longint val, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_therm  = th;
        in_bits   = b;
        wr_en     = 1'b1;
        wr_sel    = 4'(sel);
        wr_weight = 20'(val);
        push_exp(model(th, b), tag);
        if (sel <= 10) wm[sel] = val;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected out_valid", 1, 0);
            end else begin
                longint e;
                int     c;
                string  t;
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                t = tag_q.pop_front();
                check(t, longint'(out_code), e);
                check("R1 latency", longint'(cyc - c), 4);
                last_exp = e;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: got %0d pending expected 0", exp_q.size());
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        load_nominal();
        repeat (3) @(negedge clk);
        check("R2 reset out_valid", longint'(out_valid), 0);
        check("R2 reset out_code", longint'(out_code), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // Nominal weights, distinct patterns
        send(therm(8), 15'h5555, "R2 R5 nominal mid");
        send(therm(0), 15'h7FFF, "R3 level 0");
        send(therm(15), 15'h0000, "R3 level 15");
        send(15'b000_0000_1011_0111, 15'h1234, "R3 bubbled thermometer");
        send(therm(7), 15'h0001, "R4 stage 2 only high");
        send(therm(7), 15'h4000, "R4 stage 16 only high");
        send(therm(15), 15'h7FFF, "R10 saturate high");
        send(therm(0), 15'h0000, "R10 saturate low");
        idle(2);
        send(therm(9), 15'h2AAA, "R1 after gap");
        for (int i = 0; i < 40; i++)
            send(therm($urandom_range(15)), 15'($urandom), "R1 R4 stream");
        idle(8);
        check("R11 hold 1", longint'(out_code), last_exp);
        idle(3);
        check("R11 hold 2", longint'(out_code), last_exp);

        // Programmed weights
        write_w(0, 33000);
        send(therm(11), 15'h0F0F, "R6 stage 1 weight");
        write_w(10, 1000);
        send(therm(8), 15'h0200, "R6 stage 11 high");
        send(therm(8), 15'h0000, "R6 stage 11 low");
        write_w(11, 0);
        write_w(15, 0);
        write_w(13, 99999);
        send(therm(8), 15'h7C00, "R7 fixed stages high");
        send(therm(8), 15'h0000, "R7 fixed stages low");
        send_write(therm(10), 15'h7FFF, 1, 0, "R8 same-cycle write uses old");
        send(therm(10), 15'h7FFF, "R8 next sample uses new");

        // Rounding of exact halves: tail of fixed stages sums to +64
        write_w(0, 32);
        for (int k = 1; k <= 10; k++) write_w(k, 0);
        send(therm(8), 15'h5400, "R9 +1.5 rounds to 2");
        send(therm(7), 15'h5400, "R9 +0.5 rounds to 1");
        send(therm(6), 15'h5400, "R9 -0.5 rounds to 0");
        send(therm(5), 15'h5400, "R9 -1.5 rounds to -1");

        // Edge of range without clamping
        write_w(0, 34936);
        write_w(1, 1);
        send(therm(15), 15'h7FFF, "R10 top without clamp");
        send(therm(0), 15'h0000, "R10 bottom without clamp");
        for (int i = 0; i < 20; i++)
            send(therm($urandom_range(15)), 15'($urandom), "R3 R4 stream programmed");
        idle(10);
        check("R1 all results returned", longint'(exp_q.size()), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule